// File: doc/BRIEF.md
# IO Bank Freeze/Thaw Sequencer

This block walks a set of IO bank channels into and out of a frozen condition by stepping their control lines in a fixed order. Several channels are of a simple kind with five control lines. One channel, the last index, is of a richer kind that also carries a regulator reset, a termination reset, a termination calibration enable and a DLL reset. Consecutive steps are separated by minimum gaps. Some gaps are given in nanoseconds. Others are given as a number of internal-oscillator cycles. Parameters turn every gap into a whole number of clock cycles, always rounding up.

A one-cycle `freeze_req` or `thaw_req` starts a pass. The pass visits the simple channels in ascending order and then the rich channel. `busy` stays high for the whole pass, and `done` pulses when the last step lands. A per-channel `frozen` flag tracks the most recent completed operation for that channel. All control lines come from registers, and at most one sequence step takes effect on any clock edge.

Top module: `iobank_freeze_seq`

## Requirements
- R1: While reset is applied and until the first request, every channel is in its frozen condition. This means `slew_en_n`, `pullup_n`, `tristate_n`, `bushold_n` and `cfg_done` are all 0, `reg_rst`=1, `term_rst`=1, `term_cal_en`=0, `dll_rst`=1, `frozen` is all ones, and `busy`=0 and `done`=0.
- R2: Freezing a simple channel first drives its `slew_en_n`, `pullup_n` and `tristate_n` low. SHORT_GAP clock cycles later it drives `bushold_n` low and `cfg_done` low.
- R3: A pass handles channels 0..NUM_SIMPLE-1 in ascending order and then channel NUM_SIMPLE (the rich channel). The first step of a channel takes effect one clock after the last step of the previous channel, and the first step of the pass takes effect one clock after the request is accepted.
- R4: Freezing the rich channel takes three steps, each SHORT_GAP after the one before. Step one drives `slew_en_n`, `pullup_n` and `tristate_n` low. Step two drives `bushold_n` and `cfg_done` low and sets `reg_rst` and `term_rst`. Step three clears `term_cal_en` and sets `dll_rst`.
- R5: Thawing a simple channel also takes three steps, each SHORT_GAP after the one before. Step one raises `bushold_n` and `cfg_done`. Step two raises `pullup_n` and `tristate_n`. Step three raises `slew_en_n`.
- R6: Thawing the rich channel starts by clearing `dll_rst`. LONG_GAP cycles later it sets `term_cal_en`. It then waits ceil(OSC_CAL_CYCLES·OSC_PERIOD_PS/CLK_PERIOD_PS) cycles. `term_cal_en` and `dll_rst` are never high together.
- R7: The rich thaw continues in this order. It raises `bushold_n` and `cfg_done` and clears `term_rst` in one step, then waits ceil(OSC_SETTLE_CYCLES·OSC_PERIOD_PS/CLK_PERIOD_PS) cycles. Next it raises `pullup_n` and `tristate_n`, waits LONG_GAP, and clears `reg_rst`. After a further LONG_GAP it raises `slew_en_n`.
- R8: A channel's `frozen` bit changes on the same edge as that channel's last step. It is set by a freeze and cleared by a thaw.
- R9: `busy` rises on the edge that accepts a request and falls on the edge of the final step, and `done` is high for exactly that one following cycle. Requests seen while `busy` is high are ignored, and control lines do not change while idle.
- R10: If `freeze_req` and `thaw_req` are both high in an idle cycle, the pass is a freeze.
- R11: SHORT_GAP = ceil(SHORT_GAP_PS/CLK_PERIOD_PS) and LONG_GAP = ceil(LONG_GAP_PS/CLK_PERIOD_PS). With the defaults (20 ns clock) the gaps are 1, 2, 1000 and 33 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| freeze_req | input | 1 | One-cycle request to freeze all channels |
| thaw_req | input | 1 | One-cycle request to thaw all channels |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse after the final step of a pass |
| frozen | output | NUM_SIMPLE+1 | Per-channel frozen flag |
| slew_en_n | output | NUM_SIMPLE+1 | Per-channel slew enable, active low |
| pullup_n | output | NUM_SIMPLE+1 | Per-channel weak pull-up, active low |
| tristate_n | output | NUM_SIMPLE+1 | Per-channel tristate, active low |
| bushold_n | output | NUM_SIMPLE+1 | Per-channel bus-hold, active low |
| cfg_done | output | NUM_SIMPLE+1 | Per-channel configuration done, active high |
| reg_rst | output | 1 | Rich channel regulator reset |
| term_rst | output | 1 | Rich channel termination reset |
| term_cal_en | output | 1 | Rich channel termination calibration enable |
| dll_rst | output | 1 | Rich channel DLL reset |

## Verification
The bench first thaws out of the reset state, which exercises every rising edge of the sequences, including the long oscillator wait. It then issues a thaw on channels that are already thawed. This shows that a pass rewrites values without disturbing them, yet still runs its full length. A freeze request arriving mid-pass separates ignored requests from queued ones. Simultaneous freeze and thaw requests check which one wins. A new request in the same cycle as `done` checks back-to-back acceptance. A behavioural model built on a step queue predicts every output on every cycle, so a wrong step order, a wrong gap or a wrong flag edge each shows up as a mismatch in a specific cycle.

// File: rtl/iofz_pkg.sv
package iofz_pkg;

  typedef enum logic {
    OP_FREEZE = 1'b0,
    OP_THAW   = 1'b1
  } iofz_op_e;

  typedef enum logic [2:0] {
    GAP_NEXT,
    GAP_SHORT,
    GAP_LONG,
    GAP_OSC_CAL,
    GAP_OSC_SETTLE
  } iofz_gap_e;

  typedef struct packed {
    logic slew_n;
    logic pullup_n;
    logic tri_n;
    logic bhold_n;
    logic cfg_done;
    logic reg_rst;
    logic term_rst;
    logic cal_en;
    logic dll_rst;
  } iofz_lines_t;

  typedef struct packed {
    iofz_lines_t msk;
    iofz_lines_t val;
  } iofz_act_t;

  localparam int unsigned STEP_W = 3;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/iofz_rst_sync.sv
module iofz_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/iofz_wait_cnt.sv
module iofz_wait_cnt #(
  parameter int unsigned CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) begin
      cnt_d = load_val;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/iofz_step_rom.sv
module iofz_step_rom
  import iofz_pkg::*;
(
  input  iofz_op_e          op,
  input  logic              rich,
  input  logic [STEP_W-1:0] step,
  output iofz_act_t         act,
  output iofz_gap_e         gap,
  output logic              last
);
  always_comb begin
    act  = '0;
    gap  = GAP_NEXT;
    last = 1'b1;
    if (op == OP_FREEZE) begin
      case (step)
        3'd0: begin
          act.msk.slew_n   = 1'b1;
          act.msk.pullup_n = 1'b1;
          act.msk.tri_n    = 1'b1;
          gap  = GAP_SHORT;
          last = 1'b0;
        end
        3'd1: begin
          act.msk.bhold_n  = 1'b1;
          act.msk.cfg_done = 1'b1;
          if (rich) begin
            act.msk.reg_rst  = 1'b1;
            act.val.reg_rst  = 1'b1;
            act.msk.term_rst = 1'b1;
            act.val.term_rst = 1'b1;
            gap  = GAP_SHORT;
            last = 1'b0;
          end
        end
        3'd2: begin
          act.msk.cal_en  = 1'b1;
          act.msk.dll_rst = 1'b1;
          act.val.dll_rst = 1'b1;
        end
        default: ;
      endcase
    end else if (!rich) begin
      case (step)
        3'd0: begin
          act.msk.bhold_n  = 1'b1;
          act.val.bhold_n  = 1'b1;
          act.msk.cfg_done = 1'b1;
          act.val.cfg_done = 1'b1;
          gap  = GAP_SHORT;
          last = 1'b0;
        end
        3'd1: begin
          act.msk.pullup_n = 1'b1;
          act.val.pullup_n = 1'b1;
          act.msk.tri_n    = 1'b1;
          act.val.tri_n    = 1'b1;
          gap  = GAP_SHORT;
          last = 1'b0;
        end
        3'd2: begin
          act.msk.slew_n = 1'b1;
          act.val.slew_n = 1'b1;
        end
        default: ;
      endcase
    end else begin
      case (step)
        3'd0: begin
          act.msk.dll_rst = 1'b1;
          gap  = GAP_LONG;
          last = 1'b0;
        end
        3'd1: begin
          act.msk.cal_en = 1'b1;
          act.val.cal_en = 1'b1;
          gap  = GAP_OSC_CAL;
          last = 1'b0;
        end
        3'd2: begin
          act.msk.bhold_n  = 1'b1;
          act.val.bhold_n  = 1'b1;
          act.msk.cfg_done = 1'b1;
          act.val.cfg_done = 1'b1;
          act.msk.term_rst = 1'b1;
          gap  = GAP_OSC_SETTLE;
          last = 1'b0;
        end
        3'd3: begin
          act.msk.pullup_n = 1'b1;
          act.val.pullup_n = 1'b1;
          act.msk.tri_n    = 1'b1;
          act.val.tri_n    = 1'b1;
          gap  = GAP_LONG;
          last = 1'b0;
        end
        3'd4: begin
          act.msk.reg_rst = 1'b1;
          gap  = GAP_LONG;
          last = 1'b0;
        end
        3'd5: begin
          act.msk.slew_n = 1'b1;
          act.val.slew_n = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/iofz_ctrl_bank.sv
module iofz_ctrl_bank
  import iofz_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned CHW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           apply,
  input  logic [CHW-1:0] ch,
  input  iofz_act_t      act,
  output logic [NCH-1:0] slew_en_n,
  output logic [NCH-1:0] pullup_n,
  output logic [NCH-1:0] tristate_n,
  output logic [NCH-1:0] bushold_n,
  output logic [NCH-1:0] cfg_done,
  output logic           reg_rst,
  output logic           term_rst,
  output logic           term_cal_en,
  output logic           dll_rst
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic        hit;
    iofz_lines_t nxt;
    assign hit = apply && (ch == CHW'(i));

    if (i == NCH - 1) begin : g_rich
      iofz_lines_t q;
      always_comb begin
        nxt = (q & ~act.msk) | (act.val & act.msk);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '{slew_n: 1'b0, pullup_n: 1'b0, tri_n: 1'b0, bhold_n: 1'b0,
                 cfg_done: 1'b0, reg_rst: 1'b1, term_rst: 1'b1, cal_en: 1'b0,
                 dll_rst: 1'b1};
        end else if (hit) begin
          q <= nxt;
        end
      end
      assign slew_en_n[i]  = q.slew_n;
      assign pullup_n[i]   = q.pullup_n;
      assign tristate_n[i] = q.tri_n;
      assign bushold_n[i]  = q.bhold_n;
      assign cfg_done[i]   = q.cfg_done;
      assign reg_rst       = q.reg_rst;
      assign term_rst      = q.term_rst;
      assign term_cal_en   = q.cal_en;
      assign dll_rst       = q.dll_rst;
    end else begin : g_simple
      logic [4:0] q;
      logic [4:0] m5;
      logic [4:0] v5;
      assign nxt = act.val;
      always_comb begin
        m5 = {act.msk.slew_n, act.msk.pullup_n, act.msk.tri_n,
              act.msk.bhold_n, act.msk.cfg_done};
        v5 = {nxt.slew_n, nxt.pullup_n, nxt.tri_n, nxt.bhold_n, nxt.cfg_done};
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (hit) begin
          q <= (q & ~m5) | (v5 & m5);
        end
      end
      assign slew_en_n[i]  = q[4];
      assign pullup_n[i]   = q[3];
      assign tristate_n[i] = q[2];
      assign bushold_n[i]  = q[1];
      assign cfg_done[i]   = q[0];
    end
  end
endmodule

// File: rtl/iobank_freeze_seq.sv
module iobank_freeze_seq
  import iofz_pkg::*;
#(
  parameter int unsigned NUM_SIMPLE        = 3,
  parameter int unsigned CLK_PERIOD_PS     = 20000,
  parameter int unsigned OSC_PERIOD_PS     = 20000,
  parameter int unsigned SHORT_GAP_PS      = 20000,
  parameter int unsigned LONG_GAP_PS       = 40000,
  parameter int unsigned OSC_CAL_CYCLES    = 1000,
  parameter int unsigned OSC_SETTLE_CYCLES = 33,
  parameter int unsigned SYNC_STAGES       = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  freeze_req,
  input  logic                  thaw_req,
  output logic                  busy,
  output logic                  done,
  output logic [NUM_SIMPLE:0]   frozen,
  output logic [NUM_SIMPLE:0]   slew_en_n,
  output logic [NUM_SIMPLE:0]   pullup_n,
  output logic [NUM_SIMPLE:0]   tristate_n,
  output logic [NUM_SIMPLE:0]   bushold_n,
  output logic [NUM_SIMPLE:0]   cfg_done,
  output logic                  reg_rst,
  output logic                  term_rst,
  output logic                  term_cal_en,
  output logic                  dll_rst
);
  localparam int unsigned NCH       = NUM_SIMPLE + 1;
  localparam int unsigned CHW       = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned SHORT_CYC = ceil_div(SHORT_GAP_PS, CLK_PERIOD_PS);
  localparam int unsigned LONG_CYC  = ceil_div(LONG_GAP_PS, CLK_PERIOD_PS);
  localparam int unsigned CAL_CYC   = ceil_div(OSC_CAL_CYCLES * OSC_PERIOD_PS, CLK_PERIOD_PS);
  localparam int unsigned SET_CYC   = ceil_div(OSC_SETTLE_CYCLES * OSC_PERIOD_PS, CLK_PERIOD_PS);
  localparam int unsigned MAX_A     = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
  localparam int unsigned MAX_B     = (CAL_CYC > SET_CYC) ? CAL_CYC : SET_CYC;
  localparam int unsigned MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CW        = $clog2(MAX_CYC + 1);

  typedef enum logic {S_IDLE, S_RUN} seq_state_e;

  logic              srst_n;
  seq_state_e        state_q, state_d;
  iofz_op_e          op_q, op_d;
  logic [CHW-1:0]    ch_q, ch_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              done_q, done_d;
  logic [NCH-1:0]    frozen_q, frozen_d;
  logic              start, apply, expired, rich, last, seq_en, flag_en;
  iofz_act_t         act;
  iofz_gap_e         gap;
  logic [CW-1:0]     gap_cyc, load_val;

  iofz_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  assign rich  = (ch_q == CHW'(NCH - 1));
  assign start = (state_q == S_IDLE) && (freeze_req || thaw_req);
  assign apply = (state_q == S_RUN) && expired;

  iofz_step_rom u_step_rom (
    .op   (op_q),
    .rich (rich),
    .step (step_q),
    .act  (act),
    .gap  (gap),
    .last (last)
  );

  always_comb begin
    case (gap)
      GAP_SHORT:      gap_cyc = CW'(SHORT_CYC);
      GAP_LONG:       gap_cyc = CW'(LONG_CYC);
      GAP_OSC_CAL:    gap_cyc = CW'(CAL_CYC);
      GAP_OSC_SETTLE: gap_cyc = CW'(SET_CYC);
      default:        gap_cyc = CW'(1);
    endcase
    load_val = last ? '0 : (gap_cyc - 1'b1);
  end

  iofz_wait_cnt #(.CW(CW)) u_wait (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (apply),
    .load_val (load_val),
    .expired  (expired)
  );

  iofz_ctrl_bank #(.NCH(NCH), .CHW(CHW)) u_bank (
    .clk         (clk),
    .rst_n       (srst_n),
    .apply       (apply),
    .ch          (ch_q),
    .act         (act),
    .slew_en_n   (slew_en_n),
    .pullup_n    (pullup_n),
    .tristate_n  (tristate_n),
    .bushold_n   (bushold_n),
    .cfg_done    (cfg_done),
    .reg_rst     (reg_rst),
    .term_rst    (term_rst),
    .term_cal_en (term_cal_en),
    .dll_rst     (dll_rst)
  );

  always_comb begin
    state_d  = state_q;
    op_d     = op_q;
    ch_d     = ch_q;
    step_d   = step_q;
    done_d   = 1'b0;
    frozen_d = frozen_q;
    seq_en   = start || apply;
    flag_en  = apply && last;
    if (start) begin
      state_d = S_RUN;
      op_d    = freeze_req ? OP_FREEZE : OP_THAW;
      ch_d    = '0;
      step_d  = '0;
    end else if (apply) begin
      if (last) begin
        frozen_d[ch_q] = (op_q == OP_FREEZE);
        step_d         = '0;
        if (rich) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end else begin
          ch_d = ch_q + 1'b1;
        end
      end else begin
        step_d = step_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= S_IDLE;
      op_q    <= OP_FREEZE;
      ch_q    <= '0;
      step_q  <= '0;
    end else if (seq_en) begin
      state_q <= state_d;
      op_q    <= op_d;
      ch_q    <= ch_d;
      step_q  <= step_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      frozen_q <= '1;
    end else if (flag_en) begin
      frozen_q <= frozen_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign busy   = (state_q == S_RUN);
  assign done   = done_q;
  assign frozen = frozen_q;
endmodule

// File: rtl/iobank_freeze_seq_chk.sv
module iofz_seq_chk #(
  parameter int unsigned NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic [NCH-1:0] frozen,
  input logic [NCH-1:0] slew_en_n,
  input logic [NCH-1:0] pullup_n,
  input logic [NCH-1:0] tristate_n,
  input logic [NCH-1:0] bushold_n,
  input logic [NCH-1:0] cfg_done,
  input logic           reg_rst,
  input logic           term_rst,
  input logic           term_cal_en,
  input logic           dll_rst
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(slew_en_n) && $stable(pullup_n) && $stable(tristate_n)
               && $stable(bushold_n) && $stable(cfg_done) && $stable(reg_rst)
               && $stable(term_rst) && $stable(term_cal_en) && $stable(dll_rst)));

  p_cal_dll_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(term_cal_en && dll_rst));

  p_cal_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(term_cal_en) |-> $past(!dll_rst));

  p_term_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(term_rst) |-> term_cal_en);

  p_reg_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rst) |-> (pullup_n[NCH-1] && !term_rst));

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    p_cfg_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done[i] == bushold_n[i]);

    p_slew_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slew_en_n[i]) |-> (pullup_n[i] && tristate_n[i] && cfg_done[i]));

    p_hold_after_tri_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bushold_n[i]) |-> (!tristate_n[i] && !pullup_n[i] && !slew_en_n[i]));

    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frozen[i]) |-> (!cfg_done[i] && !slew_en_n[i]));

    p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frozen[i]) |-> slew_en_n[i]);
  end
endmodule

bind iobank_freeze_seq iofz_seq_chk #(.NCH(NUM_SIMPLE + 1)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .frozen      (frozen),
  .slew_en_n   (slew_en_n),
  .pullup_n    (pullup_n),
  .tristate_n  (tristate_n),
  .bushold_n   (bushold_n),
  .cfg_done    (cfg_done),
  .reg_rst     (reg_rst),
  .term_rst    (term_rst),
  .term_cal_en (term_cal_en),
  .dll_rst     (dll_rst)
);

// File: tb/iobank_freeze_seq_tb.sv
module iobank_freeze_seq_tb;
  localparam int NCH  = 4;
  localparam int RICH = 3;
  localparam int CLKP = 20000;
  localparam int G_S  = (20000 + CLKP - 1) / CLKP;
  localparam int G_L  = (40000 + CLKP - 1) / CLKP;
  localparam int G_C  = (1000 * 20000 + CLKP - 1) / CLKP;
  localparam int G_T  = (33 * 20000 + CLKP - 1) / CLKP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic freeze_req = 1'b0;
  logic thaw_req = 1'b0;
  logic busy, done, reg_rst, term_rst, term_cal_en, dll_rst;
  logic [NCH-1:0] frozen, slew_en_n, pullup_n, tristate_n, bushold_n, cfg_done;

  always #10 clk = ~clk;

  iobank_freeze_seq u_dut (
    .clk(clk), .rst_n(rst_n), .freeze_req(freeze_req), .thaw_req(thaw_req),
    .busy(busy), .done(done), .frozen(frozen), .slew_en_n(slew_en_n),
    .pullup_n(pullup_n), .tristate_n(tristate_n), .bushold_n(bushold_n),
    .cfg_done(cfg_done), .reg_rst(reg_rst), .term_rst(term_rst),
    .term_cal_en(term_cal_en), .dll_rst(dll_rst)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int done_seen = 0;
  bit cmp_on = 1'b0;

  logic [NCH-1:0] m_slew, m_pu, m_tri, m_bh, m_cfg, m_frz;
  logic m_reg, m_term, m_cal, m_dll, m_busy, m_done;
  int m_wait;
  int q_act[$];
  int q_gap[$];

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_slew = '0; m_pu = '0; m_tri = '0; m_bh = '0; m_cfg = '0; m_frz = '1;
    m_reg = 1'b1; m_term = 1'b1; m_cal = 1'b0; m_dll = 1'b1;
    m_busy = 1'b0; m_done = 1'b0; m_wait = 0;
    q_act.delete(); q_gap.delete();
  endtask

  // action code = channel*16 + thaw*8 + step
  task automatic model_apply(input int code);
    int c, th, s;
    c = code / 16; th = (code / 8) % 2; s = code % 8;
    if (th == 0) begin
      if (s == 0) begin m_slew[c] = 0; m_pu[c] = 0; m_tri[c] = 0; end
      if (s == 1) begin
        m_bh[c] = 0; m_cfg[c] = 0;
        if (c == RICH) begin m_reg = 1; m_term = 1; end
        else m_frz[c] = 1;
      end
      if (s == 2) begin m_cal = 0; m_dll = 1; m_frz[c] = 1; end
    end else if (c != RICH) begin
      if (s == 0) begin m_bh[c] = 1; m_cfg[c] = 1; end
      if (s == 1) begin m_pu[c] = 1; m_tri[c] = 1; end
      if (s == 2) begin m_slew[c] = 1; m_frz[c] = 0; end
    end else begin
      case (s)
        0: m_dll = 0;
        1: m_cal = 1;
        2: begin m_bh[c] = 1; m_cfg[c] = 1; m_term = 0; end
        3: begin m_pu[c] = 1; m_tri[c] = 1; end
        4: m_reg = 0;
        default: begin m_slew[c] = 1; m_frz[c] = 0; end
      endcase
    end
  endtask

  task automatic push(input int code, input int gap);
    q_act.push_back(code);
    q_gap.push_back(gap);
  endtask

  task automatic build(input bit thaw);
    for (int c = 0; c < RICH; c++) begin
      if (!thaw) begin push(c*16 + 0, G_S); push(c*16 + 1, 1); end
      else begin push(c*16 + 8, G_S); push(c*16 + 9, G_S); push(c*16 + 10, 1); end
    end
    if (!thaw) begin
      push(RICH*16 + 0, G_S); push(RICH*16 + 1, G_S); push(RICH*16 + 2, 1);
    end else begin
      push(RICH*16 + 8, G_L); push(RICH*16 + 9, G_C); push(RICH*16 + 10, G_T);
      push(RICH*16 + 11, G_L); push(RICH*16 + 12, G_L); push(RICH*16 + 13, 1);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        m_wait--;
        if (m_wait == 0) begin
          model_apply(q_act[0]);
          m_wait = q_gap[0];
          void'(q_act.pop_front());
          void'(q_gap.pop_front());
          if (q_act.size() == 0) begin
            m_busy = 1'b0;
            m_done = 1'b1;
          end
        end
      end else if (freeze_req || thaw_req) begin
        build(!freeze_req);
        m_busy = 1'b1;
        m_wait = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2 R3 R5 slew_en_n", 32'(slew_en_n), 32'(m_slew));
      chk("R2 R3 R5 pullup_n", 32'(pullup_n), 32'(m_pu));
      chk("R2 R3 R5 tristate_n", 32'(tristate_n), 32'(m_tri));
      chk("R2 R3 R5 bushold_n", 32'(bushold_n), 32'(m_bh));
      chk("R2 R3 R5 cfg_done", 32'(cfg_done), 32'(m_cfg));
      chk("R4 R6 R7 R11 rich lines", {28'd0, reg_rst, term_rst, term_cal_en, dll_rst},
          {28'd0, m_reg, m_term, m_cal, m_dll});
      chk("R8 frozen", 32'(frozen), 32'(m_frz));
      chk("R9 busy/done", {30'd0, busy, done}, {30'd0, m_busy, m_done});
      if (done) done_seen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R9 watchdog expired got=busy:%0b exp=idle", busy);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic pulse(input bit f, input bit t);
    @(negedge clk);
    freeze_req = f; thaw_req = t;
    @(negedge clk);
    freeze_req = 1'b0; thaw_req = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state while reset is held
    chk("R1 reset lines", {slew_en_n, pullup_n, tristate_n, bushold_n, cfg_done, 12'd0},
        32'd0);
    chk("R1 reset rich", {28'd0, reg_rst, term_rst, term_cal_en, dll_rst}, 32'b1101);
    chk("R1 reset flags", {27'd0, frozen, busy}, {27'd0, 4'hF, 1'b0});
    rst_n = 1'b1;
    cmp_on = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 after release", 32'(frozen), 32'hF);

    // thaw from reset, with a freeze request mid-pass that must be ignored (R9)
    pulse(1'b0, 1'b1);
    repeat (20) @(negedge clk);
    pulse(1'b1, 1'b0);
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R9 mid-pass request ignored", 32'(frozen), 32'h0);

    // thaw on already thawed channels
    pulse(1'b0, 1'b1);
    wait_idle();
    repeat (3) @(negedge clk);

    // simultaneous requests: freeze wins (R10)
    pulse(1'b1, 1'b1);
    wait_idle();
    repeat (2) @(negedge clk);
    chk("R10 freeze wins", 32'(frozen), 32'hF);

    // thaw, then freeze requested in the done cycle
    pulse(1'b0, 1'b1);
    wait_idle();
    freeze_req = 1'b1;
    @(negedge clk);
    freeze_req = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R9 done pulse count", 32'(done_seen), 32'd5);
    chk("R8 final flags", 32'(frozen), 32'hF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule